// File: doc/BRIEF.md
# Aliased Atomic-Update Register Bank

This block holds a small bank of 32-bit control registers behind a simple synchronous bus. The bank occupies one 4 kB window. The same window appears four times, and the two address bits just above it choose how a write is applied to the addressed word. A write can replace the word, flip bits, turn bits on or turn bits off. Surrounding logic can therefore change a single field in one bus write, without a read-modify-write and without racing another agent that touches other bits of the same word.

Every register is visible on a flat output bus for the logic it controls. The top byte of each word holds read-only status bits. These bits are loaded every cycle from a status input, and no write alias can change them. Reads are registered and have no side effects. An address whose word index lies beyond the bank reads as zero and ignores writes.

The bus has no wait states. The block has no state machine. The only sequencing is the register update on the clock edge after the write, which is described in R9.

Top module: `alias_regbank`

## Requirements
- R1: While `rst_n` is low, every register word and `bus_rdata` are zero.
- R2: A write with `bus_addr[13:12]` = 0 replaces the writable bits (31:0 outside the read-only mask) of the addressed word with `bus_wdata`.
- R3: A write with `bus_addr[13:12]` = 1 XORs `bus_wdata` into the writable bits of the addressed word.
- R4: A write with `bus_addr[13:12]` = 2 ORs `bus_wdata` into the writable bits of the addressed word.
- R5: A write with `bus_addr[13:12]` = 3 clears the writable bits of the addressed word wherever `bus_wdata` has a 1.
- R6: `bus_addr[11:2]` selects the word and `bus_addr[1:0]` is ignored. A write changes only the word it selects.
- R7: A word index at or above `NUM_REGS` (for example 8 or 1023 with the defaults) has no effect on any register when written, and reads as zero.
- R8: A read through any of the four aliases returns the addressed word on `bus_rdata` one cycle after `bus_re`, and changes no register. `bus_rdata` holds its value while `bus_re` is low.
- R9: A write takes effect at the clock edge that accepts it. A read in the same cycle as the write returns the old value, and a read in the next cycle returns the new value. Writable bits hold when no write targets the word.
- R10: Bits set in `RO_MASK` (default bits 31:24) ignore writes through all four aliases. After each clock edge they show the matching bits of `sts_in` from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 14 | Byte address: [13:12] alias, [11:2] word index, [1:0] ignored |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data or bit mask, depending on the alias |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| sts_in | input | NUM_REGS*DATA_W | Status values for the read-only bits, word i at [i*DATA_W +: DATA_W] |
| reg_q | output | NUM_REGS*DATA_W | Current register words, word i at [i*DATA_W +: DATA_W] |

## Verification
The hardest case to reach is a write and a read to the same word in the same cycle. It is especially hard when the write uses a set or clear alias aimed at the read-only byte while the status input is also changing. Three effects then meet on one edge: the read must return the old value, the writable bits must merge, and the status bits must be reloaded. The stimulus reaches this case in two ways. Directed steps drive both strobes together on the word they just loaded. A long random phase keeps the word index inside a range that spans the last real word and the first unmapped ones, and changes the status input on every cycle. A behavioural model compares every register and the read data after each edge.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

    localparam int unsigned WORD_LSB = 2;
    localparam int unsigned KIND_LSB = 12;
    localparam int unsigned BUS_AW   = 14;
    localparam int unsigned IDX_W    = KIND_LSB - WORD_LSB;

    typedef enum logic [1:0] {
        ACC_PLAIN  = 2'd0,
        ACC_TOGGLE = 2'd1,
        ACC_SETB   = 2'd2,
        ACC_CLRB   = 2'd3
    } access_kind_e;

endpackage

// File: rtl/alias_addr_decode.sv
module alias_addr_decode
    import alias_regbank_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned SEL_W    = 3
) (
    input  logic [BUS_AW-1:0]   addr,
    input  logic                we,
    output access_kind_e        kind,
    output logic [SEL_W-1:0]    word_sel,
    output logic                hit,
    output logic [NUM_REGS-1:0] wr_sel
);

    logic [IDX_W-1:0] idx;

    assign idx      = addr[KIND_LSB-1:WORD_LSB];
    assign kind     = access_kind_e'(addr[BUS_AW-1:KIND_LSB]);
    assign hit      = (32'(idx) < NUM_REGS);
    assign word_sel = idx[SEL_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
        assign wr_sel[g] = we && (32'(idx) == g);
    end

endmodule

// File: rtl/alias_reg_cell.sv
module alias_reg_cell
    import alias_regbank_pkg::*;
#(
    parameter int unsigned         DATA_W  = 32,
    parameter logic [DATA_W-1:0]   RO_MASK = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  access_kind_e      kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sts,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] WR_MASK = ~RO_MASK;

    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
        unique case (kind)
            ACC_PLAIN:  merged = wdata;
            ACC_TOGGLE: merged = q ^ wdata;
            ACC_SETB:   merged = q | wdata;
            ACC_CLRB:   merged = q & ~wdata;
            default:    merged = q;
        endcase
    end

    always_comb begin
        q_nxt = ((wr_en ? merged : q) & WR_MASK) | (sts & RO_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // R2
    plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_PLAIN) |=> ((q & WR_MASK) == ($past(wdata) & WR_MASK)));

    // R3
    toggle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_TOGGLE) |=> (((q ^ $past(q)) & WR_MASK) == ($past(wdata) & WR_MASK)));

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_SETB) |=> ((q & $past(wdata) & WR_MASK) == ($past(wdata) & WR_MASK)));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_CLRB) |=> ((q & $past(wdata) & WR_MASK) == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((q & WR_MASK) == ($past(q) & WR_MASK)));

    // R10
    ro_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((q & RO_MASK) == ($past(sts) & RO_MASK)));

endmodule

// File: rtl/alias_read_port.sv
module alias_read_port #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SEL_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         hit,
    input  logic [SEL_W-1:0]             word_sel,
    input  logic [NUM_REGS*DATA_W-1:0]   regs_flat,
    output logic [DATA_W-1:0]            rdata
);

    logic [DATA_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        if (hit) rd_word = regs_flat[32'(word_sel)*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_word;
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R7
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == '0));

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter int unsigned       NUM_REGS = 8,
    parameter int unsigned       DATA_W   = 32,
    parameter logic [DATA_W-1:0] RO_MASK  = 32'hFF00_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [13:0]                bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_re,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_REGS*DATA_W-1:0] sts_in,
    output logic [NUM_REGS*DATA_W-1:0] reg_q
);

    localparam int unsigned SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [NUM_REGS*DATA_W-1:0] WR_ALL = {NUM_REGS{~RO_MASK}};

    access_kind_e         kind;
    logic [SEL_W-1:0]     word_sel;
    logic                 hit;
    logic [NUM_REGS-1:0]  wr_sel;

    alias_addr_decode #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .kind     (kind),
        .word_sel (word_sel),
        .hit      (hit),
        .wr_sel   (wr_sel)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_cell
        alias_reg_cell #(
            .DATA_W  (DATA_W),
            .RO_MASK (RO_MASK)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_sel[r]),
            .kind  (kind),
            .wdata (bus_wdata),
            .sts   (sts_in[r*DATA_W +: DATA_W]),
            .q     (reg_q[r*DATA_W +: DATA_W])
        );
    end

    alias_read_port #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W)
    ) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_re),
        .hit       (hit),
        .word_sel  (word_sel),
        .regs_flat (reg_q),
        .rdata     (bus_rdata)
    );

    // R7
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit) |=> ((reg_q & WR_ALL) == ($past(reg_q) & WR_ALL)));

    // R6
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

endmodule

// File: tb/alias_regbank_tb.sv
`timescale 1ns/1ps
module alias_regbank_tb;

    localparam int NREG = 8;
    localparam logic [31:0] RO = 32'hFF00_0000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [13:0]       bus_addr;
    logic              bus_we;
    logic [31:0]       bus_wdata;
    logic              bus_re;
    logic [31:0]       bus_rdata;
    logic [NREG*32-1:0] sts_in;
    logic [NREG*32-1:0] reg_q;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    string cur_req = "R1";

    logic [31:0] mdl [NREG];
    logic [31:0] mdl_rd;

    always #10 clk = ~clk;

    alias_regbank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .sts_in    (sts_in),
        .reg_q     (reg_q)
    );

    function automatic logic [13:0] mk_addr(int kind, int idx, int low);
        return {kind[1:0], idx[9:0], low[1:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural reference: one update per rising edge, then compare at the falling edge.
    task automatic step();
        int idx;
        int kind;
        logic [31:0] nw;
        logic [31:0] old [NREG];
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mdl[i] = '0;
            mdl_rd = '0;
        end else begin
            idx  = int'(bus_addr[11:2]);
            kind = int'(bus_addr[13:12]);
            for (int i = 0; i < NREG; i++) old[i] = mdl[i];
            if (bus_re) mdl_rd = (idx < NREG) ? old[idx] : 32'h0;
            for (int i = 0; i < NREG; i++) begin
                nw = old[i];
                if (bus_we && idx == i) begin
                    case (kind)
                        0: nw = bus_wdata;
                        1: nw = old[i] ^ bus_wdata;
                        2: nw = old[i] | bus_wdata;
                        default: nw = old[i] & ~bus_wdata;
                    endcase
                end
                mdl[i] = (nw & ~RO) | (sts_in[i*32 +: 32] & RO);
            end
        end
        @(negedge clk);
        for (int i = 0; i < NREG; i++) chk(cur_req, reg_q[i*32 +: 32], mdl[i]);
        chk(cur_req, bus_rdata, mdl_rd);
    endtask

    task automatic op(bit we, bit re, logic [13:0] a, logic [31:0] d);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0; sts_in = '0;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        mdl_rd = '0;
        repeat (3) step();
        for (int i = 0; i < NREG; i++) chk("R1", reg_q[i*32 +: 32], 32'h0);
        chk("R1", bus_rdata, 32'h0);
        rst_n = 1'b1;
        step();

        cur_req = "R2";
        op(1, 0, mk_addr(0, 3, 0), 32'h1234_5678);
        op(0, 1, mk_addr(0, 3, 0), 32'h0);
        chk("R2", bus_rdata, 32'h0034_5678);

        cur_req = "R3";
        op(1, 0, mk_addr(1, 3, 0), 32'h00FF_00FF);
        op(0, 1, mk_addr(0, 3, 0), 32'h0);
        chk("R3", bus_rdata, 32'h00CB_5687);

        cur_req = "R4";
        op(1, 0, mk_addr(2, 3, 0), 32'h0000_F000);
        op(0, 1, mk_addr(0, 3, 0), 32'h0);
        chk("R4", bus_rdata, 32'h00CB_F687);

        cur_req = "R5";
        op(1, 0, mk_addr(3, 3, 0), 32'h00C0_0007);
        op(0, 1, mk_addr(0, 3, 0), 32'h0);
        chk("R5", bus_rdata, 32'h000B_F680);

        cur_req = "R9";
        op(1, 1, mk_addr(0, 3, 0), 32'hAAAA_5555);
        chk("R9", bus_rdata, 32'h000B_F680);
        op(0, 1, mk_addr(0, 3, 0), 32'h0);
        chk("R9", bus_rdata, 32'h00AA_5555);

        cur_req = "R8";
        for (int k = 0; k < 4; k++) begin
            op(0, 1, mk_addr(k, 3, 0), 32'h0);
            chk("R8", bus_rdata, 32'h00AA_5555);
            chk("R8", reg_q[3*32 +: 32], 32'h00AA_5555);
        end
        op(0, 1, mk_addr(0, 0, 0), 32'h0);
        chk("R8", bus_rdata, 32'h0);
        op(0, 0, mk_addr(0, 3, 0), 32'h0);
        op(0, 0, mk_addr(0, 3, 0), 32'h0);
        chk("R8", bus_rdata, 32'h0);

        cur_req = "R6";
        op(1, 0, mk_addr(0, 5, 3), 32'h0000_0F0F);
        chk("R6", reg_q[5*32 +: 32], 32'h0000_0F0F);
        chk("R6", reg_q[4*32 +: 32], 32'h0);
        chk("R6", reg_q[6*32 +: 32], 32'h0);

        cur_req = "R7";
        op(1, 0, mk_addr(0, 8, 0), 32'h00FF_FFFF);
        op(1, 0, mk_addr(2, 1023, 0), 32'h00FF_FFFF);
        chk("R7", reg_q[0 +: 32], 32'h0);
        chk("R7", reg_q[3*32 +: 32], 32'h00AA_5555);
        op(0, 1, mk_addr(1, 8, 0), 32'h0);
        chk("R7", bus_rdata, 32'h0);

        cur_req = "R10";
        for (int i = 0; i < NREG; i++) sts_in[i*32 +: 32] = 32'hA5A5_A5A5;
        op(1, 0, mk_addr(2, 1, 0), 32'hFF00_0000);
        chk("R10", reg_q[1*32 +: 32], 32'hA500_0000);
        op(1, 0, mk_addr(3, 1, 0), 32'hFF00_0000);
        chk("R10", reg_q[1*32 +: 32], 32'hA500_0000);
        op(1, 0, mk_addr(0, 1, 0), 32'h0000_0000);
        op(1, 0, mk_addr(1, 1, 0), 32'hFFFF_FFFF);
        chk("R10", reg_q[1*32 +: 32], 32'hA5FF_FFFF);
        sts_in[1*32 +: 32] = 32'h3C00_0000;
        op(0, 0, mk_addr(0, 1, 0), 32'h0);
        chk("R10", reg_q[1*32 +: 32], 32'h3CFF_FFFF);

        cur_req = "R6";
        for (int n = 0; n < 600; n++) begin
            sts_in = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            op(1'($urandom), 1'($urandom),
               mk_addr(int'($urandom % 4), int'($urandom % 11), int'($urandom % 4)),
               $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule